// File: doc/BRIEF.md
# Job Ring Register Front End

This block is the register-facing half of a single job ring for a hardware accelerator. Software sets up an input ring and an output ring over a 32-bit register bus. It then announces new work by writing a count into a jobs-added register and returns finished results by writing a count into a jobs-removed register. The block keeps the occupancy of both rings: jobs queued and not yet taken, jobs in flight, and completed results not yet consumed. It offers queued jobs to an attached job engine through a ready/start handshake and accepts a one-cycle completion strobe back from that engine. Each hand-off moves a ring index forward, wrapping at the programmed ring size.

Completions raise a job-done status bit that drives an interrupt output. The bit can be raised on every completion. With coalescing on, it rises instead once a programmed number of completions has collected, or once a programmed number of idle cycles has passed after the latest completion. A mask bit keeps the interrupt pin low without hiding the status bit.

The ring is torn down in two steps through one command bit. The first write stops job hand-off, discards queued jobs and waits for the jobs in flight to finish. A halt field reports this progress. The second write performs the ring reset. The command bit reads back as busy until that reset completes.

Top module: `jobring_regif`

## Requirements
- R1: After reset, every readable register reads zero and `irq` and `jobReady` are low.
- R2: The base registers hold 32 bits. The size registers hold RING_W bits. All of them read back what was written. Byte offsets: input base 0x00, input size 0x0C, slots available 0x14, jobs added 0x1C, output base 0x20, output size 0x2C, jobs removed 0x34, slots full 0x3C, interrupt status 0x4C, configuration 0x54, input read index 0x5C, output write index 0x64, command 0x6C. Jobs added and jobs removed read as zero.
- R3: Writing N to jobs added raises the queued count by N. The increase is limited to the free slots. Slots available reads input size minus queued jobs, which is zero when the ring is full.
- R4: `jobReady` is high while jobs are queued and no flush or reset is under way. A `jobStart` pulse while ready frees one input slot and moves the input read index up by one, wrapping to 0 at the input size. A `jobStart` pulse while not ready has no effect.
- R5: A `jobDone` pulse while at least one job is in flight raises slots full by one, saturating at the output size. It also moves the output write index up by one, wrapping at the output size. A `jobDone` with nothing in flight is ignored.
- R6: Writing N to jobs removed lowers slots full by N, never below zero.
- R7: Interrupt status bit 0 is job-done. With coalescing off (configuration bit 1 = 0), it sets on the edge that accepts a completion. Writing 1 to it clears it, and writing 0 leaves it unchanged. `irq` follows it when unmasked.
- R8: With coalescing on, job-done sets on the completion that brings the number of completions since the last interrupt up to the count threshold (configuration bits 15:8). A threshold of 0 disables this trigger.
- R9: With coalescing on and at least one completion collected, job-done sets when the timer threshold T (configuration bits 31:16) of cycles passes with no further completion, on the T-th edge after that completion. T = 0 disables this trigger.
- R10: While configuration bit 0 (mask) is 1, `irq` stays low but job-done still sets. Clearing the mask lets `irq` follow job-done again.
- R11: Writing 1 to command bit 0 in normal operation starts a flush. The flush discards queued jobs, lowers `jobReady` and makes the halt field (interrupt status bits 3:2) read 01. Jobs-added writes and command writes are ignored while the flush runs. The halt field turns to 10 on the edge after the last in-flight job completes.
- R12: Writing 1 to command bit 0 with the halt field at 10 starts a ring reset. Command bit 0 reads 1 for RST_CYCLES cycles and then clears. The reset zeroes all counts, both indices, job-done and the halt field. It leaves the base, size and configuration registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Register byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| jobReady | output | 1 | A queued job is available to the engine |
| jobStart | input | 1 | Engine takes one queued job |
| jobDone | input | 1 | Engine finished one job |
| irq | output | 1 | Job-done interrupt, after the mask |

## Verification
The hardest case to reach from the ports is a flush that has to wait: the halt field only stays at 01 if a job is still in flight when the first command write lands. The stimulus queues three jobs and lets the engine take exactly one before writing the command. It then tries a jobs-added write, a start pulse and a repeated command while the flush waits, and shows that none of them has an effect. Only then does it complete the outstanding job. By that point the ring indices have wrapped to nonzero values through earlier scenarios, so the later ring reset can be seen to zero them while the base, size and configuration registers survive. The idle-timer trigger is checked on its exact edge: the status is read one cycle before the threshold and again on it.

// File: rtl/jobring_pkg.sv
package jobring_pkg;

  localparam logic [7:0] OFF_IN_BASE   = 8'h00;
  localparam logic [7:0] OFF_IN_SIZE   = 8'h0C;
  localparam logic [7:0] OFF_SLOTS_AV  = 8'h14;
  localparam logic [7:0] OFF_JOBS_ADD  = 8'h1C;
  localparam logic [7:0] OFF_OUT_BASE  = 8'h20;
  localparam logic [7:0] OFF_OUT_SIZE  = 8'h2C;
  localparam logic [7:0] OFF_JOBS_REM  = 8'h34;
  localparam logic [7:0] OFF_SLOTS_FL  = 8'h3C;
  localparam logic [7:0] OFF_INT_STAT  = 8'h4C;
  localparam logic [7:0] OFF_CONFIG    = 8'h54;
  localparam logic [7:0] OFF_IN_RD_IDX = 8'h5C;
  localparam logic [7:0] OFF_OUT_WR_IX = 8'h64;
  localparam logic [7:0] OFF_COMMAND   = 8'h6C;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_FLUSH   = 2'd1,
    ST_HALTED  = 2'd2,
    ST_RESET   = 2'd3
  } ringState_e;

  typedef struct packed {
    logic wrInBase;
    logic wrInSize;
    logic wrOutBase;
    logic wrOutSize;
    logic wrConfig;
    logic addJobs;
    logic removeJobs;
    logic clrDone;
    logic startJob;
    logic finishJob;
    logic dropQueue;
    logic ringReset;
  } jrStrobe_t;

endpackage

// File: rtl/jobring_ctrl.sv
module jobring_ctrl
  import jobring_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wBit0,
  input  logic              jobStart,
  input  logic              jobDone,
  input  logic              engineIdle,
  input  logic              queuedNz,
  output jrStrobe_t         strb,
  output logic [1:0]        haltField,
  output logic              cmdBusy,
  output logic              jobReady
);

  localparam int CNT_W = $clog2(RST_CYCLES + 1) + 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(RST_CYCLES - 1);

  ringState_e state;
  logic [CNT_W-1:0] rstCnt;
  logic cmdWr;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == ADDR_W'(off);
  endfunction

  assign jobReady = queuedNz && (state == ST_RUN);
  assign cmdWr    = busWe && hit(busAddr, OFF_COMMAND) && wBit0;
  assign cmdBusy  = (state == ST_RESET);

  always_comb begin
    case (state)
      ST_RUN:   haltField = 2'b00;
      ST_FLUSH: haltField = 2'b01;
      default:  haltField = 2'b10;
    endcase
  end

  always_comb begin
    strb            = '0;
    strb.wrInBase   = busWe && hit(busAddr, OFF_IN_BASE);
    strb.wrInSize   = busWe && hit(busAddr, OFF_IN_SIZE);
    strb.wrOutBase  = busWe && hit(busAddr, OFF_OUT_BASE);
    strb.wrOutSize  = busWe && hit(busAddr, OFF_OUT_SIZE);
    strb.wrConfig   = busWe && hit(busAddr, OFF_CONFIG);
    strb.addJobs    = busWe && hit(busAddr, OFF_JOBS_ADD) && (state == ST_RUN);
    strb.removeJobs = busWe && hit(busAddr, OFF_JOBS_REM);
    strb.clrDone    = busWe && hit(busAddr, OFF_INT_STAT) && wBit0;
    strb.startJob   = jobStart && jobReady;
    strb.finishJob  = jobDone && !engineIdle;
    strb.dropQueue  = cmdWr && (state == ST_RUN);
    strb.ringReset  = (state == ST_RESET) && (rstCnt == LAST_CNT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_RUN;
      rstCnt <= '0;
    end else begin
      case (state)
        ST_RUN:    if (cmdWr) state <= ST_FLUSH;
        ST_FLUSH:  if (engineIdle) state <= ST_HALTED;
        ST_HALTED: if (cmdWr) begin
          state  <= ST_RESET;
          rstCnt <= '0;
        end
        default: begin
          if (rstCnt == LAST_CNT) state <= ST_RUN;
          else rstCnt <= rstCnt + 1'b1;
        end
      endcase
    end
  end

  // R11: the halt field only reports done once nothing was in flight
  assert_halt_after_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(haltField == 2'b10) |-> $past(engineIdle));

  // R12: the busy bit drops only after the full reset window
  assert_reset_length_R12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmdBusy) |-> ($past(rstCnt) == LAST_CNT));

endmodule

// File: rtl/jobring_datapath.sv
module jobring_datapath
  import jobring_pkg::*;
#(
  parameter int RING_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  jrStrobe_t         strb,
  input  logic [31:0]       wdata,
  output logic [31:0]       inBase,
  output logic [31:0]       outBase,
  output logic [RING_W-1:0] inSize,
  output logic [RING_W-1:0] outSize,
  output logic [RING_W-1:0] slotsAvail,
  output logic [RING_W-1:0] slotsFull,
  output logic [RING_W-1:0] inRdIdx,
  output logic [RING_W-1:0] outWrIdx,
  output logic [31:0]       cfgWord,
  output logic              doneFlag,
  output logic              engineIdle,
  output logic              queuedNz
);

  localparam int TMR_W = 16;
  localparam int THR_W = 8;

  logic [RING_W-1:0] queued, inflight;
  logic [TMR_W-1:0]  tmrThr, idleTmr;
  logic [THR_W-1:0]  cntThr, pendCnt;
  logic              coalEn, irqMask;
  logic [RING_W-1:0] addReq, addEff, remReq, remEff;
  logic              fullInc, fireNow;

  function automatic logic [RING_W-1:0] bump(input logic [RING_W-1:0] idx,
                                             input logic [RING_W-1:0] size);
    logic [RING_W:0] nxt;
    nxt = {1'b0, idx} + 1'b1;
    return (nxt >= {1'b0, size}) ? '0 : nxt[RING_W-1:0];
  endfunction

  assign slotsAvail = (queued > inSize) ? '0 : inSize - queued;
  assign queuedNz   = (queued != '0);
  assign engineIdle = (inflight == '0);
  assign cfgWord    = {tmrThr, cntThr, 6'b0, coalEn, irqMask};

  assign addReq  = (|wdata[31:RING_W]) ? '1 : wdata[RING_W-1:0];
  assign addEff  = (addReq > slotsAvail) ? slotsAvail : addReq;
  assign remReq  = (|wdata[31:RING_W]) ? '1 : wdata[RING_W-1:0];
  assign remEff  = strb.removeJobs ? ((remReq > slotsFull) ? slotsFull : remReq) : '0;
  assign fullInc = strb.finishJob && (slotsFull < outSize);

  always_comb begin
    if (!coalEn) fireNow = strb.finishJob;
    else if (strb.finishJob)
      fireNow = (cntThr != '0) && (({1'b0, pendCnt} + 1'b1) >= {1'b0, cntThr});
    else
      fireNow = (pendCnt != '0) && (tmrThr != '0) &&
                (({1'b0, idleTmr} + 1'b1) >= {1'b0, tmrThr});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inBase <= '0; outBase <= '0; inSize <= '0; outSize <= '0;
      tmrThr <= '0; cntThr <= '0; coalEn <= 1'b0; irqMask <= 1'b0;
    end else begin
      if (strb.wrInBase)  inBase  <= wdata;
      if (strb.wrOutBase) outBase <= wdata;
      if (strb.wrInSize)  inSize  <= wdata[RING_W-1:0];
      if (strb.wrOutSize) outSize <= wdata[RING_W-1:0];
      if (strb.wrConfig) begin
        tmrThr  <= wdata[31:16];
        cntThr  <= wdata[15:8];
        coalEn  <= wdata[1];
        irqMask <= wdata[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      queued <= '0; inflight <= '0; slotsFull <= '0;
      inRdIdx <= '0; outWrIdx <= '0;
      pendCnt <= '0; idleTmr <= '0; doneFlag <= 1'b0;
    end else if (strb.ringReset) begin
      queued <= '0; inflight <= '0; slotsFull <= '0;
      inRdIdx <= '0; outWrIdx <= '0;
      pendCnt <= '0; idleTmr <= '0; doneFlag <= 1'b0;
    end else begin
      if (strb.dropQueue) queued <= '0;
      else queued <= queued + (strb.addJobs ? addEff : '0) - RING_W'(strb.startJob);
      inflight  <= inflight + RING_W'(strb.startJob) - RING_W'(strb.finishJob);
      slotsFull <= slotsFull + RING_W'(fullInc) - remEff;
      if (strb.startJob)  inRdIdx  <= bump(inRdIdx, inSize);
      if (strb.finishJob) outWrIdx <= bump(outWrIdx, outSize);
      if (fireNow) begin
        pendCnt <= '0;
        idleTmr <= '0;
      end else if (strb.finishJob) begin
        pendCnt <= (pendCnt == '1) ? pendCnt : pendCnt + 1'b1;
        idleTmr <= '0;
      end else if (pendCnt != '0) begin
        idleTmr <= idleTmr + 1'b1;
      end
      if (fireNow) doneFlag <= 1'b1;
      else if (strb.clrDone) doneFlag <= 1'b0;
    end
  end

  // R3: an in-range jobs-added write grows the queue by exactly that count
  assert_add_count_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.addJobs && !strb.startJob && !strb.dropQueue && !strb.ringReset &&
     (wdata <= 32'(slotsAvail)))
    |=> (queued == $past(queued) + $past(wdata[RING_W-1:0])));

  // R7: without coalescing each accepted completion raises job-done
  assert_done_sets_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finishJob && !coalEn && !strb.ringReset) |=> doneFlag);

  // R12: the ring reset leaves every count and index at zero
  assert_reset_clears_R12: assert property (@(posedge clk) disable iff (!rstN)
    strb.ringReset |=> (queued == '0 && slotsFull == '0 && inRdIdx == '0 &&
                        outWrIdx == '0 && !doneFlag));

endmodule

// File: rtl/jobring_regif.sv
module jobring_regif
  import jobring_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int RING_W     = 10,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              jobReady,
  input  logic              jobStart,
  input  logic              jobDone,
  output logic              irq
);

  jrStrobe_t         strb;
  logic [1:0]        haltField;
  logic              cmdBusy, engineIdle, queuedNz, doneFlag;
  logic [31:0]       inBase, outBase, cfgWord;
  logic [RING_W-1:0] inSize, outSize, slotsAvail, slotsFull, inRdIdx, outWrIdx;

  jobring_ctrl #(.ADDR_W(ADDR_W), .RST_CYCLES(RST_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .wBit0(busWdata[0]), .jobStart(jobStart), .jobDone(jobDone),
    .engineIdle(engineIdle), .queuedNz(queuedNz), .strb(strb),
    .haltField(haltField), .cmdBusy(cmdBusy), .jobReady(jobReady)
  );

  jobring_datapath #(.RING_W(RING_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata),
    .inBase(inBase), .outBase(outBase), .inSize(inSize), .outSize(outSize),
    .slotsAvail(slotsAvail), .slotsFull(slotsFull), .inRdIdx(inRdIdx),
    .outWrIdx(outWrIdx), .cfgWord(cfgWord), .doneFlag(doneFlag),
    .engineIdle(engineIdle), .queuedNz(queuedNz)
  );

  assign irq = doneFlag && !cfgWord[0];

  always_comb begin
    case (busAddr)
      ADDR_W'(OFF_IN_BASE):   busRdata = inBase;
      ADDR_W'(OFF_IN_SIZE):   busRdata = 32'(inSize);
      ADDR_W'(OFF_SLOTS_AV):  busRdata = 32'(slotsAvail);
      ADDR_W'(OFF_OUT_BASE):  busRdata = outBase;
      ADDR_W'(OFF_OUT_SIZE):  busRdata = 32'(outSize);
      ADDR_W'(OFF_SLOTS_FL):  busRdata = 32'(slotsFull);
      ADDR_W'(OFF_INT_STAT):  busRdata = {28'b0, haltField, 1'b0, doneFlag};
      ADDR_W'(OFF_CONFIG):    busRdata = cfgWord;
      ADDR_W'(OFF_IN_RD_IDX): busRdata = 32'(inRdIdx);
      ADDR_W'(OFF_OUT_WR_IX): busRdata = 32'(outWrIdx);
      ADDR_W'(OFF_COMMAND):   busRdata = {31'b0, cmdBusy};
      default:                busRdata = '0;
    endcase
  end

endmodule

// File: tb/tb_jobring_regif.sv
`timescale 1ns/1ps
module tb_jobring_regif;

  localparam int RST_CYCLES = 4;
  localparam logic [7:0] A_IN_BASE = 8'h00, A_IN_SIZE = 8'h0C, A_AVAIL = 8'h14,
    A_ADD = 8'h1C, A_OUT_BASE = 8'h20, A_OUT_SIZE = 8'h2C, A_REM = 8'h34,
    A_FULL = 8'h3C, A_STAT = 8'h4C, A_CFG = 8'h54, A_RIDX = 8'h5C,
    A_WIDX = 8'h64, A_CMD = 8'h6C;

  logic clk = 1'b0, rstN = 1'b0, busWe = 1'b0, jobStart = 1'b0, jobDone = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic jobReady, irq;
  int checks = 0, fails = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  jobring_regif #(.RST_CYCLES(RST_CYCLES)) dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .jobReady(jobReady),
    .jobStart(jobStart), .jobDone(jobDone), .irq(irq));

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic pulseStart();
    @(negedge clk); jobStart = 1'b1;
    @(negedge clk); jobStart = 1'b0;
  endtask

  task automatic pulseDone();
    @(negedge clk); jobDone = 1'b1;
    @(negedge clk); jobDone = 1'b0;
  endtask

  task automatic queueAndStart(input int n);
    wr(A_ADD, n);
    for (int i = 0; i < n; i++) pulseStart();
  endtask

  task automatic test_reset();
    rd(A_AVAIL, rv); check("R1", "slots avail", rv, 0);
    rd(A_FULL, rv);  check("R1", "slots full", rv, 0);
    rd(A_STAT, rv);  check("R1", "status", rv, 0);
    rd(A_CMD, rv);   check("R1", "command", rv, 0);
    rd(A_RIDX, rv);  check("R1", "read index", rv, 0);
    check("R1", "irq/jobReady", {irq, jobReady}, 0);
  endtask

  task automatic test_regs();
    wr(A_IN_BASE, 32'hA5A5_0000); wr(A_IN_SIZE, 4);
    wr(A_OUT_BASE, 32'h1234_5670); wr(A_OUT_SIZE, 3);
    rd(A_IN_BASE, rv);  check("R2", "input base", rv, 32'hA5A5_0000);
    rd(A_IN_SIZE, rv);  check("R2", "input size", rv, 4);
    rd(A_OUT_BASE, rv); check("R2", "output base", rv, 32'h1234_5670);
    rd(A_OUT_SIZE, rv); check("R2", "output size", rv, 3);
    rd(A_ADD, rv);      check("R2", "jobs added reads 0", rv, 0);
  endtask

  task automatic test_add();
    wr(A_ADD, 3);
    rd(A_AVAIL, rv); check("R3", "avail after 3", rv, 1);
    check("R4", "ready with queue", jobReady, 1);
    wr(A_ADD, 5);
    rd(A_AVAIL, rv); check("R3", "full ring reads 0", rv, 0);
  endtask

  task automatic test_engine();
    pulseStart();
    rd(A_AVAIL, rv); check("R4", "slot freed", rv, 1);
    rd(A_RIDX, rv);  check("R4", "index 1", rv, 1);
    for (int i = 0; i < 3; i++) pulseStart();
    rd(A_RIDX, rv);  check("R4", "index wraps", rv, 0);
    rd(A_AVAIL, rv); check("R4", "all slots free", rv, 4);
    check("R4", "ready low when empty", jobReady, 0);
    pulseStart();
    rd(A_RIDX, rv);  check("R4", "start ignored when not ready", rv, 0);
  endtask

  task automatic test_complete();
    pulseDone();
    rd(A_FULL, rv); check("R5", "slots full 1", rv, 1);
    rd(A_WIDX, rv); check("R5", "write index 1", rv, 1);
    rd(A_STAT, rv); check("R7", "done bit set", rv, 1);
    check("R7", "irq", irq, 1);
    for (int i = 0; i < 3; i++) pulseDone();
    rd(A_FULL, rv); check("R5", "saturates", rv, 3);
    rd(A_WIDX, rv); check("R5", "index wraps", rv, 1);
    pulseDone();
    rd(A_WIDX, rv); check("R5", "done ignored when idle", rv, 1);
  endtask

  task automatic test_status_remove();
    wr(A_STAT, 0);
    rd(A_STAT, rv); check("R7", "write 0 keeps", rv, 1);
    wr(A_STAT, 1);
    rd(A_STAT, rv); check("R7", "w1c clears", rv, 0);
    check("R7", "irq low", irq, 0);
    wr(A_REM, 2);
    rd(A_FULL, rv); check("R6", "remove 2", rv, 1);
    wr(A_REM, 5);
    rd(A_FULL, rv); check("R6", "floor at 0", rv, 0);
  endtask

  task automatic test_count_coal();
    wr(A_CFG, (0 << 16) | (3 << 8) | 2);
    queueAndStart(3);
    pulseDone(); pulseDone();
    rd(A_STAT, rv); check("R8", "below threshold", rv, 0);
    pulseDone();
    rd(A_STAT, rv); check("R8", "threshold reached", rv, 1);
    wr(A_REM, 3); wr(A_STAT, 1);
  endtask

  task automatic test_timer_coal();
    wr(A_CFG, (5 << 16) | (10 << 8) | 2);
    queueAndStart(1);
    pulseDone();
    repeat (4) @(negedge clk);
    rd(A_STAT, rv); check("R9", "before timer", rv, 0);
    @(negedge clk);
    rd(A_STAT, rv); check("R9", "on timer edge", rv, 1);
    wr(A_REM, 3); wr(A_STAT, 1);
  endtask

  task automatic test_mask();
    wr(A_CFG, 1);
    queueAndStart(1);
    pulseDone();
    rd(A_STAT, rv); check("R10", "status sets when masked", rv, 1);
    check("R10", "irq masked", irq, 0);
    wr(A_CFG, 0);
    check("R10", "irq after unmask", irq, 1);
    wr(A_REM, 3); wr(A_STAT, 1);
  endtask

  task automatic test_flush_reset();
    int busy;
    wr(A_CFG, 32'h0007_0300);
    wr(A_ADD, 3);
    pulseStart();
    wr(A_CMD, 1);
    rd(A_STAT, rv);  check("R11", "halt 01", rv[3:2], 2'b01);
    rd(A_AVAIL, rv); check("R11", "queue dropped", rv, 4);
    check("R11", "ready low", jobReady, 0);
    wr(A_ADD, 2);
    rd(A_AVAIL, rv); check("R11", "add ignored", rv, 4);
    pulseStart();
    wr(A_CMD, 1);
    rd(A_CMD, rv);   check("R11", "cmd ignored in flush", rv, 0);
    pulseDone();
    rd(A_STAT, rv);  check("R11", "still 01", rv[3:2], 2'b01);
    @(negedge clk);
    rd(A_STAT, rv);  check("R11", "halt 10", rv[3:2], 2'b10);
    rd(A_RIDX, rv);  check("R4", "read index before reset", rv, 2);
    wr(A_CMD, 1);
    busy = 0;
    for (int i = 0; i < 20; i++) begin
      rd(A_CMD, rv);
      if (rv[0] !== 1'b1) break;
      busy++;
      @(negedge clk);
    end
    check("R12", "busy cycles", busy, RST_CYCLES);
    rd(A_STAT, rv);  check("R12", "status cleared", rv, 0);
    rd(A_FULL, rv);  check("R12", "slots full 0", rv, 0);
    rd(A_RIDX, rv);  check("R12", "read index 0", rv, 0);
    rd(A_WIDX, rv);  check("R12", "write index 0", rv, 0);
    rd(A_IN_BASE, rv); check("R12", "base kept", rv, 32'hA5A5_0000);
    rd(A_OUT_SIZE, rv); check("R12", "size kept", rv, 3);
    rd(A_CFG, rv);   check("R12", "config kept", rv, 32'h0007_0300);
    wr(A_ADD, 1);
    check("R12", "running again", jobReady, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_regs();
    test_add();
    test_engine();
    test_complete();
    test_status_remove();
    test_count_coal();
    test_timer_coal();
    test_mask();
    test_flush_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule